// File: doc/BRIEF.md
# Three-Wire Addressed Control-Register Receiver

This block receives a write-only serial control stream on three pins (data, mode and clock) and uses it to program the feature registers of an audio converter. While the mode line is low, eight clocked bits form an address byte. Its upper six bits must equal the device identifier `000101`, and its lower two bits pick a transfer type. While the mode line is high, every complete byte is a data byte. The selection made by the last address byte holds for any number of data bytes. Within the selected type, the top bits of each data byte pick the target register, and the remaining bits carry the value.

The three pins are oversampled in the system clock domain through synchronizers, and the rising edges of the bus clock are detected there. The bus runs at no more than 64 times the audio sample rate, so the system clock is far faster than the bus. A strap input selects a static-pin fallback. In that mode the synchronized pins drive mute-left, mute-right and de-emphasis directly, and every other feature output shows its default of zero.

Top module: `ctlbus_rx`

## Requirements
- R1: After reset, every feature output is zero, and both mute outputs are zero.
- R2: Bits are taken on the rising edge of the bus clock, least significant bit first. After address byte `0x14` (device `000101`, type `00` = data), a data byte writes its bits 5..0 into the register picked by bits 7..6: `00` = volume left, `01` = volume right, `10` = bass boost, `11` = treble.
- R3: An address byte whose bits 7..2 differ from `000101` deselects the device, and the data bytes that follow write nothing.
- R4: Transfer types `01` and `11` (address bits 1..0) are unused, and the data bytes that follow them write nothing.
- R5: Under type `10` (status), a byte with bit 7 = 0 sets mode from bits 6..5, de-emphasis from bit 4, right manipulation from bits 3..2 and left manipulation from bits 1..0. A status byte with bit 7 = 1 is ignored.
- R6: The device and type selection persists across any number of data bytes until the next address byte.
- R7: Every edge of the mode line clears the bit count, so a partial byte writes nothing and the next full byte is aligned from its first bit.
- R8: While `static_mode` is 1, `mute_left` follows the data pin, `mute_right` follows the mode pin and `deemph` follows the clock pin. All other feature outputs read zero, and no register is written. While `static_mode` is 0, both mutes are 0.
- R9: A register changes only after the eighth bit of a byte; seven bits leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| static_mode | input | 1 | 1 = pins drive mutes and de-emphasis directly |
| bus_data | input | 1 | Serial data pin |
| bus_mode | input | 1 | Mode pin: low = address phase, high = data phase |
| bus_clk | input | 1 | Serial bit clock pin |
| vol_left | output | 6 | Left volume register |
| vol_right | output | 6 | Right volume register |
| bass_boost | output | 6 | Bass boost register |
| treble | output | 6 | Treble register |
| proc_mode | output | 2 | Processing mode field |
| deemph | output | 1 | De-emphasis enable |
| manip_right | output | 2 | Right channel manipulation |
| manip_left | output | 2 | Left channel manipulation |
| mute_left | output | 1 | Left mute (static-pin mode only) |
| mute_right | output | 1 | Right mute (static-pin mode only) |

## Verification
The stimulus covers each of the four data selectors in one run, because separate values in every field show both the bit order and the register decode. It also sends status bytes with bit 7 clear and set, and address bytes with a wrong identifier and with both unused type codes, each followed by a write that must be dropped. A byte cut off by mode-line toggles, followed by a full byte, separates counter clearing from plain continuation. Seven bits checked before the eighth show that nothing is committed before a byte completes. The static-pin part drives opposite pin patterns and then returns to bus mode to confirm that the stored values reappear.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 6;
    localparam int ID_W   = 6;
    localparam logic [ID_W-1:0] DEV_ID = 6'b000101;

    typedef enum logic [1:0] {
        XFER_DATA   = 2'b00,
        XFER_RSVD1  = 2'b01,
        XFER_STATUS = 2'b10,
        XFER_RSVD3  = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        SEL_VOL_L  = 2'b00,
        SEL_VOL_R  = 2'b01,
        SEL_BASS   = 2'b10,
        SEL_TREBLE = 2'b11
    } dsel_e;

    typedef struct packed {
        logic [VAL_W-1:0] vol_l;
        logic [VAL_W-1:0] vol_r;
        logic [VAL_W-1:0] bass;
        logic [VAL_W-1:0] treble;
        logic [1:0]       mode;
        logic             deemph;
        logic [1:0]       manip_r;
        logic [1:0]       manip_l;
    } regs_t;

    function automatic logic id_match(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: ID_W] == DEV_ID;
    endfunction

    function automatic xfer_e xfer_of(input logic [BYTE_W-1:0] b);
        return xfer_e'(b[1:0]);
    endfunction

    function automatic dsel_e dsel_of(input logic [BYTE_W-1:0] b);
        return dsel_e'(b[BYTE_W-1 -: 2]);
    endfunction

    function automatic logic [VAL_W-1:0] value_of(input logic [BYTE_W-1:0] b);
        return b[VAL_W-1:0];
    endfunction

endpackage

// File: rtl/ctlbus_sync.sv
module ctlbus_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ctlbus_shifter.sv
module ctlbus_shifter
    import ctlbus_pkg::*;
#(
    parameter int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_s,
    input  logic              m_s,
    input  logic              c_s,
    output logic              byte_vld,
    output logic              byte_addr,
    output logic [BYTE_W-1:0] byte_q,
    output logic              mode_edge,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              m_q;
    logic              c_q;
    logic              clk_rise;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shnext;

    assign mode_edge = m_s != m_q;
    assign clk_rise  = c_s && !c_q;
    assign shnext    = {d_s, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q       <= 1'b0;
            c_q       <= 1'b0;
            shreg     <= '0;
            bit_cnt   <= '0;
            byte_vld  <= 1'b0;
            byte_addr <= 1'b0;
            byte_q    <= '0;
        end else begin
            m_q      <= m_s;
            c_q      <= c_s;
            byte_vld <= 1'b0;
            if (mode_edge) begin
                bit_cnt <= '0;
            end else if (clk_rise) begin
                shreg <= shnext;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    byte_vld  <= 1'b1;
                    byte_q    <= shnext;
                    byte_addr <= !m_s;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ctlbus_regfile.sv
module ctlbus_regfile
    import ctlbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              byte_vld,
    input  logic              byte_addr,
    input  logic [BYTE_W-1:0] byte_q,
    output regs_t             regs,
    output logic              sel_ok,
    output xfer_e             sel_type
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= '0;
            sel_ok   <= 1'b0;
            sel_type <= XFER_DATA;
        end else if (byte_vld && wr_en) begin
            if (byte_addr) begin
                sel_ok   <= id_match(byte_q);
                sel_type <= xfer_of(byte_q);
            end else if (sel_ok) begin
                case (sel_type)
                    XFER_DATA: begin
                        case (dsel_of(byte_q))
                            SEL_VOL_L:  regs.vol_l  <= value_of(byte_q);
                            SEL_VOL_R:  regs.vol_r  <= value_of(byte_q);
                            SEL_BASS:   regs.bass   <= value_of(byte_q);
                            SEL_TREBLE: regs.treble <= value_of(byte_q);
                            default: ;
                        endcase
                    end
                    XFER_STATUS: begin
                        if (!byte_q[7]) begin
                            regs.mode    <= byte_q[6:5];
                            regs.deemph  <= byte_q[4];
                            regs.manip_r <= byte_q[3:2];
                            regs.manip_l <= byte_q[1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctlbus_rx.sv
module ctlbus_rx
    import ctlbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             static_mode,
    input  logic             bus_data,
    input  logic             bus_mode,
    input  logic             bus_clk,
    output logic [VAL_W-1:0] vol_left,
    output logic [VAL_W-1:0] vol_right,
    output logic [VAL_W-1:0] bass_boost,
    output logic [VAL_W-1:0] treble,
    output logic [1:0]       proc_mode,
    output logic             deemph,
    output logic [1:0]       manip_right,
    output logic [1:0]       manip_left,
    output logic             mute_left,
    output logic             mute_right
);
    localparam int NPINS = 3;
    localparam int CNT_W = $clog2(BYTE_W);

    logic [NPINS-1:0]  pins_s;
    logic              byte_vld;
    logic              byte_addr;
    logic [BYTE_W-1:0] byte_q;
    logic              mode_edge;
    logic [CNT_W-1:0]  bit_cnt;
    regs_t             regs;
    logic              sel_ok;
    xfer_e             sel_type;
    regs_t             shown;

    ctlbus_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({bus_clk, bus_mode, bus_data}),
        .sync_out (pins_s)
    );

    ctlbus_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .d_s       (pins_s[0]),
        .m_s       (pins_s[1]),
        .c_s       (pins_s[2]),
        .byte_vld  (byte_vld),
        .byte_addr (byte_addr),
        .byte_q    (byte_q),
        .mode_edge (mode_edge),
        .bit_cnt   (bit_cnt)
    );

    ctlbus_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (!static_mode),
        .byte_vld  (byte_vld),
        .byte_addr (byte_addr),
        .byte_q    (byte_q),
        .regs      (regs),
        .sel_ok    (sel_ok),
        .sel_type  (sel_type)
    );

    always_comb begin
        if (static_mode) begin
            shown        = '0;
            shown.deemph = pins_s[2];
            mute_left    = pins_s[0];
            mute_right   = pins_s[1];
        end else begin
            shown      = regs;
            mute_left  = 1'b0;
            mute_right = 1'b0;
        end
    end

    assign vol_left    = shown.vol_l;
    assign vol_right   = shown.vol_r;
    assign bass_boost  = shown.bass;
    assign treble      = shown.treble;
    assign proc_mode   = shown.mode;
    assign deemph      = shown.deemph;
    assign manip_right = shown.manip_r;
    assign manip_left  = shown.manip_l;
endmodule

// File: rtl/ctlbus_rx_chk.sv
module ctlbus_rx_chk
    import ctlbus_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              static_mode,
    input logic              byte_vld,
    input logic              byte_addr,
    input logic [BYTE_W-1:0] byte_q,
    input logic              mode_edge,
    input logic [CNT_W-1:0]  bit_cnt,
    input regs_t             regs,
    input logic              sel_ok,
    input logic [1:0]        sel_type,
    input logic [VAL_W-1:0]  vol_left,
    input logic [VAL_W-1:0]  vol_right,
    input logic [VAL_W-1:0]  bass_boost,
    input logic [VAL_W-1:0]  treble,
    input logic [1:0]        proc_mode,
    input logic [1:0]        manip_right,
    input logic [1:0]        manip_left,
    input logic              mute_left,
    input logic              mute_right
);
    p_hold_between_bytes_r9: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(regs));

    p_deselected_r3: assert property (@(posedge clk) disable iff (rst)
        byte_vld && !byte_addr && !sel_ok |=> $stable(regs));

    p_unused_type_r4: assert property (@(posedge clk) disable iff (rst)
        byte_vld && !byte_addr && sel_type[0] |=> $stable(regs));

    p_status_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        byte_vld && !byte_addr && sel_type == 2'b10 && byte_q[7] |=> $stable(regs));

    p_count_clear_r7: assert property (@(posedge clk) disable iff (rst)
        mode_edge |=> bit_cnt == '0);

    p_static_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        static_mode |=> $stable(regs));

    p_static_defaults_r8: assert property (@(posedge clk) disable iff (rst)
        static_mode |-> vol_left == '0 && vol_right == '0 && bass_boost == '0 &&
                        treble == '0 && proc_mode == '0 && manip_right == '0 &&
                        manip_left == '0);

    p_bus_unmuted_r8: assert property (@(posedge clk) disable iff (rst)
        !static_mode |-> !mute_left && !mute_right);
endmodule

bind ctlbus_rx ctlbus_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .static_mode (static_mode),
    .byte_vld    (byte_vld),
    .byte_addr   (byte_addr),
    .byte_q      (byte_q),
    .mode_edge   (mode_edge),
    .bit_cnt     (bit_cnt),
    .regs        (regs),
    .sel_ok      (sel_ok),
    .sel_type    (sel_type),
    .vol_left    (vol_left),
    .vol_right   (vol_right),
    .bass_boost  (bass_boost),
    .treble      (treble),
    .proc_mode   (proc_mode),
    .manip_right (manip_right),
    .manip_left  (manip_left),
    .mute_left   (mute_left),
    .mute_right  (mute_right)
);

// File: tb/ctlbus_rx_test.sv
module ctlbus_rx_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic static_mode = 1'b0;
    logic bus_data = 1'b0;
    logic bus_mode = 1'b1;
    logic bus_clk = 1'b0;
    logic [5:0] vol_left, vol_right, bass_boost, treble;
    logic [1:0] proc_mode, manip_right, manip_left;
    logic deemph, mute_left, mute_right;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [5:0] e_vl = '0, e_vr = '0, e_bb = '0, e_tr = '0;
    logic [1:0] e_md = '0, e_mr = '0, e_ml = '0;
    logic       e_de = 1'b0;
    bit         m_sel = 1'b0;
    int         m_type = 0;

    always #10 clk = ~clk;

    ctlbus_rx uut (
        .clk(clk), .rst(rst), .static_mode(static_mode),
        .bus_data(bus_data), .bus_mode(bus_mode), .bus_clk(bus_clk),
        .vol_left(vol_left), .vol_right(vol_right), .bass_boost(bass_boost),
        .treble(treble), .proc_mode(proc_mode), .deemph(deemph),
        .manip_right(manip_right), .manip_left(manip_left),
        .mute_left(mute_left), .mute_right(mute_right)
    );

    task automatic model_byte(input int b, input bit is_addr);
        if (is_addr) begin
            m_sel  = ((b >> 2) == 5);
            m_type = b % 4;
        end else if (m_sel) begin
            if (m_type == 0) begin
                case (b / 64)
                    0: e_vl = 6'(b % 64);
                    1: e_vr = 6'(b % 64);
                    2: e_bb = 6'(b % 64);
                    default: e_tr = 6'(b % 64);
                endcase
            end else if (m_type == 2 && b < 128) begin
                e_md = 2'((b / 32) % 4);
                e_de = 1'((b / 16) % 2);
                e_mr = 2'((b / 4) % 4);
                e_ml = 2'(b % 4);
            end
        end
    endtask

    task automatic check(input string tag);
        logic [34:0] act, exp;
        act = {vol_left, vol_right, bass_boost, treble, proc_mode, deemph,
               manip_right, manip_left, mute_left, mute_right};
        if (static_mode)
            exp = {24'd0, 2'd0, bus_clk, 4'd0, bus_data, bus_mode};
        else
            exp = {e_vl, e_vr, e_bb, e_tr, e_md, e_de, e_mr, e_ml, 2'b00};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bus_data = b;
        wait_clk(3);
        bus_clk = 1'b1;
        wait_clk(3);
        bus_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_addr(input logic [7:0] v);
        bus_mode = 1'b1;
        wait_clk(4);
        bus_mode = 1'b0;
        wait_clk(4);
        send_bits(v, 8);
        wait_clk(10);
        model_byte(int'(v), 1'b1);
    endtask

    task automatic send_data(input logic [7:0] v);
        if (!bus_mode) begin
            bus_mode = 1'b1;
            wait_clk(4);
        end
        send_bits(v, 8);
        wait_clk(10);
        model_byte(int'(v), 1'b0);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);
        check("R1 reset state");

        send_addr(8'h14);
        send_data(8'h2A);
        check("R2 volume left");
        send_data(8'h55);
        check("R2 volume right");
        send_data(8'hBF);
        check("R2 bass boost");
        send_data(8'hC1);
        check("R6 treble after several bytes");

        send_addr(8'h16);
        send_data(8'h5B);
        check("R5 status write");
        send_data(8'hFF);
        check("R5 status bit7 ignored");

        send_bits(8'h25, 7);
        wait_clk(10);
        check("R9 seven bits no change");
        send_bit(1'b0);
        wait_clk(10);
        model_byte(8'h25, 1'b0);
        check("R9 eighth bit commits");

        send_bits(8'hFF, 5);
        bus_mode = 1'b0;
        wait_clk(4);
        bus_mode = 1'b1;
        wait_clk(10);
        check("R7 partial byte dropped");
        send_data(8'h07);
        check("R7 realigned byte");

        send_addr(8'h15);
        send_data(8'h2A);
        check("R4 type 01 no write");
        send_addr(8'h17);
        send_data(8'h9B);
        check("R4 type 11 no write");

        send_addr(8'h18);
        send_data(8'h3F);
        check("R3 wrong address no write");

        send_addr(8'h14);
        send_data(8'h01);
        check("R2 reselect writes volume left");

        static_mode = 1'b1;
        bus_data = 1'b1;
        bus_mode = 1'b0;
        bus_clk = 1'b1;
        wait_clk(6);
        check("R8 static pattern A");
        bus_data = 1'b0;
        bus_mode = 1'b1;
        bus_clk = 1'b0;
        wait_clk(6);
        check("R8 static pattern B");
        static_mode = 1'b0;
        wait_clk(6);
        check("R8 bus values restored");

        send_addr(8'h14);
        send_data(8'hC5);
        check("R2 treble after static");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule